// File: doc/BRIEF.md
# SPI Register-Access Slave Bridge

This block is an SPI slave that lets an external host reach a 32-bit internal register space. Each serial frame first carries a 24-bit header with a write flag and a word address, and then a 32-bit payload. Writes are assembled and issued on a simple request/acknowledge register bus. Reads are issued as soon as the header is complete, and the returned word is shifted back to the host. The bus may take a variable number of cycles to acknowledge.

The host picks the payload byte order and bit order at run time through a small control register. The control value is mirrored inside each byte, so a write to it decodes the same way whatever layout is currently selected. A second local register sets how many dummy bytes come between the header and the read data. It also holds a sticky flag, set when the first read-data bit had to go out before the internal access had finished, and a read-only interface identity field. A soft-reset input returns this interface configuration to its defaults.

SPI mode 0 is used. The host drives MOSI and samples MISO on the rising edge of SCLK, and the bridge changes MISO after the falling edge. All SPI inputs are oversampled in the system clock domain.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, `spi_miso` is 0 and `bus_req` is 0.
- R2: The header is 24 bits, sent most-significant bit first. Bit 23 is 1 for a write and 0 for a read. Bits 22:0 are the word address, which is the byte address divided by 4, and this value appears unchanged on `bus_addr`.
- R3: Payload bit k of the stream (k = 0..31) carries word bit 8*B + b. B is k/8 for little-endian or 3 - k/8 for big-endian. b is 7 - k%8 for MSB-first or k%8 for LSB-first. The same mapping is used for write data and read data.
- R4: Word address 0 is the layout control register. On a write, bit 0 selects big-endian and bit 1 selects LSB-first. Layout codes are 0 = little-endian MSB-first, 1 = big-endian MSB-first, 2 = little-endian LSB-first, 3 = big-endian LSB-first. A read returns the byte {be, lsb, 0000, lsb, be} repeated in all four bytes, so 0x81818181 selects big-endian MSB-first under any current layout. A new layout applies from the next frame.
- R5: Word address 1 is the configuration/status register. Bits 3:0 are the read padding in bytes, bit 16 is the too-slow flag, and bits 31:24 always read 0x02. All other bits read 0.
- R6: On a read, padding*8 SCLK cycles pass after the header before the first data bit. MISO is 0 throughout the header and the padding.
- R7: The too-slow flag is set when the first read-data bit is due and the read word is not yet available. It stays set until a write to word 1 with bit 16 = 1, a reset or a soft reset. A write with bit 16 = 0 leaves it set.
- R8: `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` held steady, until the first cycle in which `bus_ack` is high. It drops in the next cycle, and read data is taken from `bus_rdata` in the acknowledged cycle.
- R9: A write frame that ends (chip select goes high) before all 24 + 32 bits have arrived is discarded. It causes no bus access and no local register change.
- R10: A soft-reset pulse returns the layout to code 0, the padding to 0 and the too-slow flag to 0.
- R11: Accesses to word addresses 0 and 1 are served locally and never raise `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Pulse that returns the interface configuration to defaults |
| spi_sclk | input | 1 | SPI clock from host, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 23 | Internal bus word address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_rdata | input | 32 | Internal bus read data, valid with acknowledge |

## Verification
The hardest situation to reach is a read whose bus acknowledge arrives after the first data bit is due, because the flag it sets shows up only in a later read of the status register. The bench's bus responder has a programmable acknowledge delay. It runs a read with no padding and a long delay to set the flag. It then runs the same delay with two bytes of padding to show the flag stays clear and the data arrives intact. It also cuts write frames short at several bit counts and checks that nothing is issued and nothing is changed.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
  localparam int PAYLOAD_W = 32;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_PAD, PH_DATA, PH_DONE} phase_t;

  // Serial payload position -> word bit index for the selected layout
  function automatic logic [4:0] lane_bit(input logic [4:0] k, input logic be, input logic lsb);
    logic [1:0] byt;
    logic [2:0] bi;
    byt = be ? (2'd3 - k[4:3]) : k[4:3];
    bi  = lsb ? k[2:0] : (3'd7 - k[2:0]);
    return {byt, bi};
  endfunction

  // Rebuild a word from bits stored in arrival order
  function automatic logic [PAYLOAD_W-1:0] unpack_word(input logic [PAYLOAD_W-1:0] raw,
                                                       input logic be, input logic lsb);
    logic [PAYLOAD_W-1:0] w;
    w = '0;
    for (int k = 0; k < PAYLOAD_W; k++) w[lane_bit(5'(k), be, lsb)] = raw[k];
    return w;
  endfunction
endpackage

// File: rtl/bridge_sync.sv
`timescale 1ns/1ps
module bridge_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/bridge_local_regs.sv
`timescale 1ns/1ps
module bridge_local_regs #(
  parameter int PAD_W = 4,
  parameter logic [7:0] IF_ID = 8'h02
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic        wr_sel,     // 0: layout control, 1: config/status
  input  logic [31:0] wdata,
  input  logic        slow_set,
  output logic        cfg_be,
  output logic        cfg_lsb,
  output logic [PAD_W-1:0] pad,
  output logic        slow_flag,
  output logic [31:0] ctrl_word,
  output logic [31:0] cfg_word
);
  logic [7:0] ctrl_byte;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_be    <= 1'b0;
      cfg_lsb   <= 1'b0;
      pad       <= '0;
      slow_flag <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) begin
        cfg_be  <= wdata[0];
        cfg_lsb <= wdata[1];
      end
      if (wr_en && wr_sel) pad <= wdata[PAD_W-1:0];
      if (slow_set) slow_flag <= 1'b1;
      else if (wr_en && wr_sel && wdata[16]) slow_flag <= 1'b0;
    end
  end

  assign ctrl_byte = {cfg_be, cfg_lsb, 4'b0000, cfg_lsb, cfg_be};
  assign ctrl_word = {4{ctrl_byte}};

  always_comb begin
    cfg_word = '0;
    cfg_word[31:24] = IF_ID;
    cfg_word[16] = slow_flag;
    cfg_word[PAD_W-1:0] = pad;
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    slow_set && !soft_rst |=> slow_flag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    slow_flag && !soft_rst && !(wr_en && wr_sel && wdata[16]) |=> slow_flag);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel && wdata[16] && !slow_set |=> !slow_flag);
  p_soft_defaults_r10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !cfg_be && !cfg_lsb && pad == '0 && !slow_flag);
endmodule

// File: rtl/bridge_bus_master.sv
`timescale 1ns/1ps
module bridge_bus_master #(
  parameter int AW = 23,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          st_we,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          rd_done,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_done   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req <= 1'b0;
          if (!bus_we) begin
            rd_data <= bus_rdata;
            rd_done <= 1'b1;
          end
        end
      end else if (start) begin
        bus_req   <= 1'b1;
        bus_we    <= st_we;
        bus_addr  <= st_addr;
        bus_wdata <= st_wdata;
      end
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  p_req_release_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);
endmodule

// File: rtl/spi_reg_bridge.sv
`timescale 1ns/1ps
module spi_reg_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int PAD_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [PAYLOAD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [PAYLOAD_W-1:0] bus_rdata
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int CNT_W = PAD_W + 3;
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(PAYLOAD_W - 1);

  logic sclk_s, cs_n_s, mosi_s, sclk_d, rise, fall;
  phase_t phase;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdr;
  logic [PAYLOAD_W-1:0] raw, rd_word;
  logic fr_we, fr_local, rd_go, wr_go, rd_valid, slow_set;
  logic [ADDR_W-1:0] fr_addr;
  logic cfg_be, cfg_lsb, slow_flag, bm_rd_done;
  logic [PAD_W-1:0] pad;
  logic [PAYLOAD_W-1:0] ctrl_word, cfg_word, bm_rdata;

  bridge_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({spi_sclk, spi_cs_n, spi_mosi}), .q({sclk_s, cs_n_s, mosi_s}));

  assign rise = sclk_s && !sclk_d;
  assign fall = !sclk_s && sclk_d;
  assign fr_local = (fr_addr >> 1) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; cnt <= '0; hdr <= '0; raw <= '0;
      fr_we <= 1'b0; fr_addr <= '0; spi_miso <= 1'b0; sclk_d <= 1'b0;
      rd_go <= 1'b0; wr_go <= 1'b0; slow_set <= 1'b0;
      rd_valid <= 1'b0; rd_word <= '0;
    end else begin
      sclk_d   <= sclk_s;
      rd_go    <= 1'b0;
      wr_go    <= 1'b0;
      slow_set <= 1'b0;
      if (rd_go && fr_local) begin
        rd_word  <= fr_addr[0] ? cfg_word : ctrl_word;
        rd_valid <= 1'b1;
      end
      if (bm_rd_done) begin
        rd_word  <= bm_rdata;
        rd_valid <= 1'b1;
      end
      if (cs_n_s) begin
        phase    <= PH_IDLE;
        spi_miso <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            phase    <= PH_ADDR;
            cnt      <= '0;
            rd_valid <= 1'b0;
          end
          PH_ADDR: if (rise) begin
            hdr <= {hdr[HDR_W-2:0], mosi_s};
            cnt <= cnt + 1'b1;
            if (cnt == HDR_LAST) begin
              fr_we   <= hdr[HDR_W-2];
              fr_addr <= {hdr[ADDR_W-2:0], mosi_s};
              cnt     <= '0;
              if (hdr[HDR_W-2]) phase <= PH_DATA;
              else begin
                rd_go <= 1'b1;
                phase <= (pad == '0) ? PH_DATA : PH_PAD;
              end
            end
          end
          PH_PAD: if (rise) begin
            if (cnt == {pad, 3'b000} - 1'b1) begin
              phase <= PH_DATA;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          PH_DATA: begin
            if (fall && !fr_we) begin
              spi_miso <= rd_valid ? rd_word[lane_bit(cnt[4:0], cfg_be, cfg_lsb)] : 1'b0;
              if (cnt == '0 && !rd_valid) slow_set <= 1'b1;
            end
            if (rise) begin
              if (fr_we) raw[cnt[4:0]] <= mosi_s;
              cnt <= cnt + 1'b1;
              if (cnt == DATA_LAST) begin
                phase <= PH_DONE;
                wr_go <= fr_we;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  bridge_local_regs #(.PAD_W(PAD_W), .IF_ID(8'h02)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_go && fr_local), .wr_sel(fr_addr[0]),
    .wdata(unpack_word(raw, cfg_be, cfg_lsb)), .slow_set(slow_set),
    .cfg_be(cfg_be), .cfg_lsb(cfg_lsb), .pad(pad), .slow_flag(slow_flag),
    .ctrl_word(ctrl_word), .cfg_word(cfg_word));

  bridge_bus_master #(.AW(ADDR_W), .DW(PAYLOAD_W)) u_bus (
    .clk(clk), .rst(rst),
    .start((wr_go || rd_go) && !fr_local), .st_we(wr_go), .st_addr(fr_addr),
    .st_wdata(unpack_word(raw, cfg_be, cfg_lsb)),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_done(bm_rd_done), .rd_data(bm_rdata));

  p_local_nobus_r11: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr >> 1) != '0);
  p_quiet_hdr_pad_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR || phase == PH_PAD) |-> !spi_miso);
  p_write_complete_r9: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> phase == PH_DONE || cs_n_s);
endmodule

// File: tb/sim_spi_reg_bridge.sv
`timescale 1ns/1ps
module sim_spi_reg_bridge;
  localparam time TCLK = 4ns;
  localparam time H = 32ns;

  logic clk = 0, rst = 1, soft_rst = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, bus_req, bus_we, bus_ack = 0;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0;

  int n_tests = 0, n_fail = 0;
  int lat = 2;
  logic [31:0] resp_data = 0;
  int acc_cnt = 0, wr_cnt = 0;
  logic [22:0] last_addr = 0;
  logic last_we = 0;
  logic [31:0] last_wdata = 0;
  logic tb_be = 0, tb_lsb = 0;
  logic [3:0] tb_pad = 0;
  bit finished = 0;

  spi_reg_bridge u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  always #(TCLK/2) clk = ~clk;

  // Bus responder with programmable acknowledge delay
  initial begin
    int wait_c;
    wait_c = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 0;
      else if (bus_req) begin
        wait_c++;
        if (wait_c >= lat) begin
          wait_c = 0;
          bus_ack = 1;
          bus_rdata = resp_data;
          last_addr = bus_addr; last_we = bus_we; last_wdata = bus_wdata;
          acc_cnt++;
          if (bus_we) wr_cnt++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ser_pos(input int k);
    int byt, bi;
    byt = tb_be ? 3 - k / 8 : k / 8;
    bi  = tb_lsb ? k % 8 : 7 - k % 8;
    return byt * 8 + bi;
  endfunction

  function automatic logic [31:0] ctrl_pat(input logic be, input logic lsb);
    logic [7:0] b;
    b = {be, lsb, 4'b0000, lsb, be};
    return {b, b, b, b};
  endfunction

  task automatic sbit(input logic v, output logic s);
    mosi = v;
    #H;
    s = miso;
    sclk = 1;
    #H;
    sclk = 0;
  endtask

  // One frame; ndata = number of payload bits sent on writes
  task automatic frame(input logic wr, input logic [22:0] wa, input logic [31:0] wd,
                       input int ndata, output logic [31:0] rd, output logic pad_dirty);
    logic [23:0] hdr;
    logic s;
    hdr = {wr, wa};
    rd = '0;
    pad_dirty = 0;
    cs_n = 0;
    for (int i = 23; i >= 0; i--) begin
      sbit(hdr[i], s);
      if (s) pad_dirty = 1;
    end
    if (wr) begin
      for (int k = 0; k < ndata; k++) sbit(wd[ser_pos(k)], s);
    end else begin
      for (int p = 0; p < tb_pad * 8; p++) begin
        sbit(1'b1, s);
        if (s) pad_dirty = 1;
      end
      for (int k = 0; k < 32; k++) begin
        sbit(1'b0, s);
        rd[ser_pos(k)] = s;
      end
    end
    #H;
    cs_n = 1;
    #(4*H);
  endtask

  task automatic wr32(input logic [22:0] wa, input logic [31:0] wd);
    logic [31:0] r; logic d;
    frame(1'b1, wa, wd, 32, r, d);
  endtask

  task automatic rd32(input logic [22:0] wa, output logic [31:0] r);
    logic d;
    frame(1'b0, wa, '0, 0, r, d);
  endtask

  task automatic set_layout(input logic be, input logic lsb);
    wr32(23'd0, ctrl_pat(be, lsb));
    tb_be = be; tb_lsb = lsb;
  endtask

  task automatic set_cfg(input logic [31:0] v);
    wr32(23'd1, v);
    tb_pad = v[3:0];
  endtask

  // {we[57], layout[56:55], word address[54:32], data[31:0]}
  localparam logic [57:0] VEC [8] = '{
    {1'b1, 2'd0, 23'h5A3C71, 32'h12345678},
    {1'b1, 2'd1, 23'h00F00D, 32'hA1B2C3D4},
    {1'b1, 2'd2, 23'h7FFFFF, 32'h80000001},
    {1'b1, 2'd3, 23'h000002, 32'hC0FFEE11},
    {1'b0, 2'd0, 23'h123456, 32'hDEADBEEF},
    {1'b0, 2'd1, 23'h000003, 32'h01020304},
    {1'b0, 2'd2, 23'h2AAAAA, 32'hF00000AA},
    {1'b0, 2'd3, 23'h400000, 32'h5500FF33}
  };

  initial begin
    #(400us);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic dirty;
    int a0, w0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    repeat (3) @(negedge clk);
    chk("R1", "miso after reset", 32'(miso), 0);
    chk("R1", "bus_req after reset", 32'(bus_req), 0);

    a0 = acc_cnt;
    rd32(23'd1, r);
    chk("R5", "cfgstat default", r, 32'h0200_0000);
    chk("R11", "no bus access for local read", acc_cnt, a0);

    // Table walk: layouts x reads/writes (R2, R3, R8)
    foreach (VEC[i]) begin
      logic [57:0] v;
      v = VEC[i];
      set_layout(v[55], v[56]);
      if (v[57]) begin
        w0 = wr_cnt;
        wr32(v[54:32], v[31:0]);
        chk("R2", "write address", 32'(last_addr), 32'(v[54:32]));
        chk("R2", "write flag", 32'(last_we), 1);
        chk("R3", "write data layout", last_wdata, v[31:0]);
        chk("R8", "one write issued", wr_cnt, w0 + 1);
      end else begin
        resp_data = v[31:0];
        rd32(v[54:32], r);
        chk("R2", "read address", 32'(last_addr), 32'(v[54:32]));
        chk("R2", "read flag", 32'(last_we), 0);
        chk("R3", "read data layout", r, v[31:0]);
      end
      chk("R8", "bus_req released", 32'(bus_req), 0);
    end

    // R4: mirrored control value works under any layout
    set_layout(1'b1, 1'b1);
    wr32(23'd0, 32'h8181_8181);
    tb_be = 1; tb_lsb = 0;
    rd32(23'd0, r);
    chk("R4", "control readback big-endian MSB", r, 32'h8181_8181);
    wr32(23'd0, 32'h0000_0000);
    tb_be = 0; tb_lsb = 0;
    rd32(23'd0, r);
    chk("R4", "control readback little-endian MSB", r, 32'h0);

    // R6: padding with slow bus still returns data, miso quiet in pad
    set_cfg(32'h0000_0002);
    lat = 40;
    resp_data = 32'h3C5A_96E1;
    frame(1'b0, 23'h000100, '0, 0, r, dirty);
    chk("R6", "padded read data", r, 32'h3C5A_96E1);
    chk("R6", "miso zero in header and pad", 32'(dirty), 0);
    rd32(23'd1, r);
    chk("R7", "no flag with enough padding", r, 32'h0200_0002);

    // R7: no padding, slow bus -> sticky flag
    set_cfg(32'h0000_0000);
    frame(1'b0, 23'h000100, '0, 0, r, dirty);
    lat = 2;
    rd32(23'd1, r);
    chk("R7", "flag set when data late", r, 32'h0201_0000);
    set_cfg(32'h0000_0000);
    rd32(23'd1, r);
    chk("R7", "flag survives write of 0", r, 32'h0201_0000);
    set_cfg(32'h0001_0000);
    rd32(23'd1, r);
    chk("R7", "flag cleared by write of 1", r, 32'h0200_0000);

    // R9: truncated write frames
    w0 = wr_cnt;
    frame(1'b1, 23'h000200, 32'hFFFF_FFFF, 20, r, dirty);
    frame(1'b1, 23'h000200, 32'hFFFF_FFFF, 31, r, dirty);
    chk("R9", "short bus writes dropped", wr_cnt, w0);
    frame(1'b1, 23'd1, 32'h0000_0005, 31, r, dirty);
    rd32(23'd1, r);
    chk("R9", "short local write dropped", r, 32'h0200_0000);

    // R10: soft reset restores defaults
    set_layout(1'b1, 1'b0);
    set_cfg(32'h0000_0003);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    tb_be = 0; tb_lsb = 0; tb_pad = 0;
    rd32(23'd1, r);
    chk("R10", "cfgstat after soft reset", r, 32'h0200_0000);
    rd32(23'd0, r);
    chk("R10", "layout after soft reset", r, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule